// File: doc/BRIEF.md
# Multi-channel periodic compare timer

This block holds a set of independent 16-bit timer channels behind one small synchronous register port. Each channel counts up on ticks from its own prescaler, which divides the block clock by 1, 4, 16 or 64. The channel compares the count with a compare register. When they are equal, the next tick raises a status flag and, if clear-on-match is selected, takes the counter back to zero. This gives a periodic event source whose period is set by the compare value and the prescale choice. A per-channel level interrupt follows the flag, masked by an enable bit.

Software starts and stops channels through one start register, which has one bit per channel. Each channel has a window of sixteen byte addresses. The counter and the compare register are reached only with 16-bit accesses, and every other register only with 8-bit accesses. The flag is acknowledged in two steps: first a read of the status register that sees it set, then a write of 0 to it.

Each channel holds two state machines. The run machine has the states STOPPED and COUNTING, linked by START (a 1 written to the channel's start bit) and HALT (a 0 written to it). The flag machine has the states CLEAR, PENDING and ARMED. MATCH (compare event) moves CLEAR to PENDING. READ (a status read) moves PENDING to ARMED. ACK (a write of 0 to bit 0) moves ARMED to CLEAR. ACK_RACE (an ACK in the same cycle as a compare event) moves ARMED to PENDING.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads 0, every channel is stopped and every irq bit is 0.
- R2: Bit c of the start register (address 0x00, byte access) starts channel c when written 1 and stops it when written 0. It reads back the run state. A stopped channel holds its counter value.
- R3: Control bits [2:0] pick the tick rate: 0 = every cycle, 1 = every 4th, 2 = every 16th, 3 to 7 = every 64th. The first tick comes the chosen number of cycles after the starting write. The prescaler restarts from zero on each start.
- R4: With control bits [7:5] = 001, a tick while counter equals compare loads the counter with 0 and sets status bit 0 on that same edge.
- R5: With any other value of control bits [7:5], the match tick still sets the flag, but the counter increments. It wraps from 0xFFFF to 0.
- R6: irq[c] is high exactly when channel c's status bit 0 and interrupt-enable bit 0 (channel offset 4) are both 1.
- R7: Writing a byte with bit 0 = 0 to status (offset 5) clears the flag only if a status read since the flag was set returned 1. A write with bit 0 = 1, or a write of 0 with no such read, leaves the flag set.
- R8: If a compare event falls in the same cycle as a clearing write, the flag stays set and needs a new read before it can be cleared.
- R9: Counter (offset 6) and compare (offset 8) are accessed only by 16-bit accesses. Control (0), mode (1), I/O control (2), enable (4) and status (5) are accessed only by 8-bit accesses using data bits [7:0]. An access of the wrong width writes nothing and reads 0.
- R10: Counter and compare can be written and read back. A started channel counts on from the value written.
- R11: Channels are independent. Channel c's window starts at byte address 16*(c+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational from address |
| irq | output | NUM_CH | Per-channel interrupt level |

## Verification
The hardest case to reach from the ports is a compare event in the very cycle of a clearing write to an armed flag. The bench gets there by running a channel at full rate with a small compare value, so that events come a known number of cycles apart. It reads status right after the first event to arm the flag, then waits an exact number of idle cycles so that the clearing write lands on the edge of the second event. Restart of the prescaler is shown by starting and stopping a divide-by-4 channel twice, each time just short of its first tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        CH_STOPPED,
        CH_COUNTING
    } ch_state_e;

    typedef enum logic [1:0] {
        FLG_CLEAR,
        FLG_PENDING,
        FLG_ARMED
    } flg_state_e;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 4;

    localparam logic [OFS_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [OFS_W-1:0] OFS_MODE = 4'h1;
    localparam logic [OFS_W-1:0] OFS_IOC  = 4'h2;
    localparam logic [OFS_W-1:0] OFS_IEN  = 4'h4;
    localparam logic [OFS_W-1:0] OFS_STAT = 4'h5;
    localparam logic [OFS_W-1:0] OFS_CNT  = 4'h6;
    localparam logic [OFS_W-1:0] OFS_CMP  = 4'h8;

    localparam logic [2:0] CLR_ON_MATCH = 3'b001;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int STEP_LOG2 = 2,
    parameter int LEVELS    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       tick
);
    localparam int PRE_W  = STEP_LOG2 * (LEVELS - 1);
    localparam int CODE_W = $clog2(LEVELS);

    logic [PRE_W-1:0]  pre_q;
    logic [PRE_W-1:0]  last;
    logic [CODE_W-1:0] code;

    // selections above the slowest rate saturate to the slowest rate
    always_comb begin
        if (sel >= 3'(LEVELS - 1)) code = CODE_W'(LEVELS - 1);
        else                       code = CODE_W'(sel);
    end

    always_comb begin
        last = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (code == CODE_W'(i)) last = PRE_W'((1 << (STEP_LOG2 * i)) - 1);
        end
    end

    assign tick = run && (pre_q == last);

    always_ff @(posedge clk) begin
        if (!rst_n)            pre_q <= '0;
        else if (!run || tick) pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
    end

    // R3: a divided rate never ticks on two edges in a row
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && code != '0 && run) |=> !tick);

    // R3: the prescaler starts from zero after a stop
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> pre_q == '0);

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic stat_rd,
    input  logic stat_wr,
    input  logic wr_bit0,
    output logic flag
);
    flg_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FLG_CLEAR;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLG_CLEAR:   if (set_evt) st_d = FLG_PENDING;
            FLG_PENDING: if (stat_rd) st_d = FLG_ARMED;
            FLG_ARMED: begin
                if (stat_wr && !wr_bit0) st_d = set_evt ? FLG_PENDING : FLG_CLEAR;
            end
            default:     st_d = FLG_CLEAR;
        endcase
    end

    always_comb begin
        flag = (st_q != FLG_CLEAR);
    end

    // R7: a write without a prior read of the set flag leaves it set
    p_no_blind_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FLG_PENDING && stat_wr) |=> flag);

    // R7: an acknowledge of an armed flag clears it
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FLG_ARMED && stat_wr && !wr_bit0 && !set_evt) |=> !flag);

    // R8: a compare event always leaves the flag set
    p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int STEP_LOG2 = 2,
    parameter int LEVELS    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_wr,
    input  logic             go_bit,
    input  logic             sel,
    input  logic             wr,
    input  logic             rd,
    input  logic             wide,
    input  logic [OFS_W-1:0] ofs,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             running,
    output logic             irq
);
    ch_state_e st_q, st_d;

    logic [BYTE_W-1:0] ctrl_q, mode_q, ioc_q, ien_q;
    logic [CNT_W-1:0]  cnt_q, cmp_q;
    logic              byte_wr, word_wr, cnt_wr, cmp_wr;
    logic              tick, match, clr_mode, set_evt, flag;
    logic              stat_rd, stat_wr;

    assign byte_wr  = sel && wr && !wide;
    assign word_wr  = sel && wr && wide;
    assign cnt_wr   = word_wr && (ofs == OFS_CNT);
    assign cmp_wr   = word_wr && (ofs == OFS_CMP);
    assign stat_rd  = sel && rd && !wide && (ofs == OFS_STAT);
    assign stat_wr  = byte_wr && (ofs == OFS_STAT);
    assign match    = (cnt_q == cmp_q);
    assign clr_mode = (ctrl_q[7:5] == CLR_ON_MATCH);
    assign set_evt  = tick && match;

    // run state machine
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_STOPPED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_STOPPED:  if (go_wr && go_bit)  st_d = CH_COUNTING;
            CH_COUNTING: if (go_wr && !go_bit) st_d = CH_STOPPED;
            default:     st_d = CH_STOPPED;
        endcase
    end

    always_comb begin
        running = (st_q == CH_COUNTING);
        irq     = flag && ien_q[0];
    end

    tmr_prescale #(
        .STEP_LOG2 (STEP_LOG2),
        .LEVELS    (LEVELS)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .sel   (ctrl_q[2:0]),
        .tick  (tick)
    );

    tmr_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_evt),
        .stat_rd (stat_rd),
        .stat_wr (stat_wr),
        .wr_bit0 (wdata[0]),
        .flag    (flag)
    );

    // byte-wide setup registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mode_q <= '0;
            ioc_q  <= '0;
            ien_q  <= '0;
        end else if (byte_wr) begin
            unique case (ofs)
                OFS_CTRL: ctrl_q <= wdata[BYTE_W-1:0];
                OFS_MODE: mode_q <= wdata[BYTE_W-1:0];
                OFS_IOC:  ioc_q  <= wdata[BYTE_W-1:0];
                OFS_IEN:  ien_q  <= wdata[BYTE_W-1:0];
                default:  ;
            endcase
        end
    end

    // counter and compare register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '0;
        end else begin
            if (cmp_wr) cmp_q <= wdata;
            if (cnt_wr)                     cnt_q <= wdata;
            else if (tick && match && clr_mode) cnt_q <= '0;
            else if (tick)                  cnt_q <= cnt_q + 1'b1;
        end
    end

    // read mux, wrong-width accesses return 0
    always_comb begin
        rdata = '0;
        if (!wide) begin
            unique case (ofs)
                OFS_CTRL: rdata = CNT_W'(ctrl_q);
                OFS_MODE: rdata = CNT_W'(mode_q);
                OFS_IOC:  rdata = CNT_W'(ioc_q);
                OFS_IEN:  rdata = CNT_W'(ien_q);
                OFS_STAT: rdata = CNT_W'(flag);
                default:  rdata = '0;
            endcase
        end else begin
            unique case (ofs)
                OFS_CNT: rdata = cnt_q;
                OFS_CMP: rdata = cmp_q;
                default: rdata = '0;
            endcase
        end
    end

    // R2: a stopped channel holds its count
    p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_STOPPED && !cnt_wr) |=> cnt_q == $past(cnt_q));

    // R3: an ordinary tick steps the count by one
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !match && !cnt_wr) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R4: clear-on-match returns the counter to zero
    p_match_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && match && clr_mode && !cnt_wr) |=> (cnt_q == '0 && flag));

    // R5: without clear-on-match the counter passes the compare value
    p_match_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && match && !clr_mode && !cnt_wr) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R6: no interrupt while the enable bit is low
    p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_wr && ofs == OFS_IEN && !wdata[0]) |=> !irq);

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 6,
    parameter int STEP_LOG2 = 2,
    parameter int LEVELS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_wide,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int WIN_W = ADDR_W - OFS_W;

    logic [WIN_W-1:0]  win;
    logic [OFS_W-1:0]  ofs;
    logic              go_wr;
    logic [NUM_CH-1:0] running;
    logic [NUM_CH-1:0] ch_sel;
    logic [CNT_W-1:0]  ch_rdata [NUM_CH];

    assign win   = bus_addr[ADDR_W-1:OFS_W];
    assign ofs   = bus_addr[OFS_W-1:0];
    assign go_wr = bus_wr && !bus_wide && (win == '0) && (ofs == '0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_sel[c] = (win == WIN_W'(c + 1));

        tmr_channel #(
            .CNT_W     (CNT_W),
            .STEP_LOG2 (STEP_LOG2),
            .LEVELS    (LEVELS)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .go_wr   (go_wr),
            .go_bit  (bus_wdata[c]),
            .sel     (ch_sel[c]),
            .wr      (bus_wr),
            .rd      (bus_rd),
            .wide    (bus_wide),
            .ofs     (ofs),
            .wdata   (bus_wdata),
            .rdata   (ch_rdata[c]),
            .running (running[c]),
            .irq     (irq[c])
        );

        // R2: the start bit takes the written value on the next edge
        p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
            go_wr |=> running[c] == $past(bus_wdata[c]));
    end

    always_comb begin
        bus_rdata = '0;
        if (win == '0) begin
            if (!bus_wide && ofs == '0) bus_rdata = CNT_W'(running);
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (ch_sel[c]) bus_rdata = ch_rdata[c];
            end
        end
    end

    // R1: nothing runs or interrupts right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (running == '0 && irq == '0));

endmodule

// File: tb/tmr_bank_test.sv
`timescale 1ns/1ps
module tmr_bank_test;
    localparam logic [5:0] A_GO = 6'h00;
    localparam logic [5:0] C0   = 6'h10;
    localparam logic [5:0] C1   = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  addr;
    logic        wr, rd, wide;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [1:0]  irq;

    int checks = 0;
    int fails  = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    tmr_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_rd    (rd),
        .bus_wide  (wide),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [5:0] a, input logic w, input logic [15:0] d);
        addr = a; wide = w; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic brd(input logic [5:0] a, input logic w, input logic [15:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        addr = a; wide = w; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares each read against the scoreboard
    always begin
        @(negedge clk);
        #1;
        if (rd) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard: read with no expected item, got %h expected none", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run hung, got timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wide = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        brd(A_GO, 0, 16'h0000, "R1 start reg");
        brd(C0 + 0, 0, 16'h0000, "R1 ctrl");
        brd(C0 + 4, 0, 16'h0000, "R1 enable");
        brd(C0 + 5, 0, 16'h0000, "R1 status");
        brd(C0 + 6, 1, 16'h0000, "R1 counter");
        brd(C0 + 8, 1, 16'h0000, "R1 compare");
        brd(C1 + 6, 1, 16'h0000, "R1 ch1 counter");
        check("R1 irq", {14'd0, irq}, 16'h0000);

        // R9 / R10 access widths and read-back
        bwr(C0 + 6, 1, 16'h1234);
        brd(C0 + 6, 1, 16'h1234, "R10 counter readback");
        brd(C0 + 6, 0, 16'h0000, "R9 byte read of counter");
        bwr(C0 + 8, 0, 16'h0055);
        brd(C0 + 8, 1, 16'h0000, "R9 byte write to compare ignored");
        bwr(C0 + 0, 1, 16'h0023);
        brd(C0 + 0, 0, 16'h0000, "R9 wide write to ctrl ignored");
        bwr(C0 + 0, 0, 16'hAB23);
        brd(C0 + 0, 0, 16'h0023, "R9 ctrl uses low byte");
        bwr(C0 + 1, 0, 16'h00A5);
        brd(C0 + 1, 0, 16'h00A5, "R9 mode readback");
        bwr(C0 + 2, 0, 16'h003C);
        brd(C0 + 2, 0, 16'h003C, "R9 io ctrl readback");
        bwr(C0 + 8, 1, 16'hFFFF);
        brd(C0 + 8, 1, 16'hFFFF, "R10 compare readback");
        bwr(C1 + 8, 1, 16'hFFFF);

        // R2 / R3 divide by 1
        bwr(C0 + 0, 0, 16'h0000);
        bwr(C0 + 6, 1, 16'h0000);
        bwr(A_GO, 0, 16'h0001);
        idle(9);
        bwr(A_GO, 0, 16'h0000);
        brd(C0 + 6, 1, 16'd10, "R3 div1 count");
        brd(A_GO, 0, 16'h0000, "R2 stopped readback");
        idle(5);
        brd(C0 + 6, 1, 16'd10, "R2 stopped channel holds");
        brd(C1 + 6, 1, 16'h0000, "R11 ch1 untouched");

        // R3 divide by 4
        bwr(C0 + 0, 0, 16'h0001);
        bwr(C0 + 6, 1, 16'h0000);
        bwr(A_GO, 0, 16'h0001);
        idle(20);
        bwr(A_GO, 0, 16'h0000);
        brd(C0 + 6, 1, 16'd5, "R3 div4 count");

        // R3 prescaler restarts on each start
        bwr(C0 + 6, 1, 16'h0000);
        bwr(A_GO, 0, 16'h0001);
        idle(2);
        bwr(A_GO, 0, 16'h0000);
        bwr(A_GO, 0, 16'h0001);
        idle(2);
        bwr(A_GO, 0, 16'h0000);
        brd(C0 + 6, 1, 16'd0, "R3 prescaler restart");

        // R3 divide by 16
        bwr(C0 + 0, 0, 16'h0002);
        bwr(A_GO, 0, 16'h0001);
        idle(40);
        bwr(A_GO, 0, 16'h0000);
        brd(C0 + 6, 1, 16'd2, "R3 div16 count");

        // R3 divide by 64
        bwr(C0 + 0, 0, 16'h0003);
        bwr(C0 + 6, 1, 16'h0000);
        bwr(A_GO, 0, 16'h0001);
        idle(200);
        bwr(A_GO, 0, 16'h0000);
        brd(C0 + 6, 1, 16'd3, "R3 div64 count");

        // R3 select 7 saturates to 64
        bwr(C0 + 0, 0, 16'h0007);
        bwr(C0 + 6, 1, 16'h0000);
        bwr(A_GO, 0, 16'h0001);
        idle(129);
        bwr(A_GO, 0, 16'h0000);
        brd(C0 + 6, 1, 16'd2, "R3 select 7 count");

        // R10 counting resumes from a written value
        bwr(C0 + 0, 0, 16'h0000);
        bwr(C0 + 6, 1, 16'h0100);
        bwr(A_GO, 0, 16'h0001);
        idle(4);
        bwr(A_GO, 0, 16'h0000);
        brd(C0 + 6, 1, 16'h0105, "R10 count from written value");

        // R11 two channels together
        bwr(C1 + 0, 0, 16'h0001);
        bwr(C0 + 6, 1, 16'h0000);
        bwr(A_GO, 0, 16'h0003);
        brd(A_GO, 0, 16'h0003, "R2 both running readback");
        idle(6);
        bwr(A_GO, 0, 16'h0000);
        brd(C0 + 6, 1, 16'd8, "R11 ch0 count");
        brd(C1 + 6, 1, 16'd2, "R11 ch1 count");

        // R4 clear on match, R6 irq
        bwr(C0 + 0, 0, 16'h0020);
        bwr(C0 + 8, 1, 16'd5);
        bwr(C0 + 6, 1, 16'h0000);
        bwr(C0 + 4, 0, 16'h0001);
        bwr(A_GO, 0, 16'h0001);
        idle(5);
        check("R4 no flag before match tick", {15'd0, irq[0]}, 16'h0000);
        idle(1);
        check("R4 flag on match tick", {15'd0, irq[0]}, 16'h0001);
        bwr(A_GO, 0, 16'h0000);
        brd(C0 + 6, 1, 16'd1, "R4 counter cleared then counted");
        bwr(C0 + 4, 0, 16'h0000);
        check("R6 irq masked", {15'd0, irq[0]}, 16'h0000);
        bwr(C0 + 4, 0, 16'h0001);
        check("R6 irq unmasked", {15'd0, irq[0]}, 16'h0001);

        // R7 acknowledge protocol
        bwr(C0 + 5, 0, 16'h00FE);
        brd(C0 + 5, 0, 16'h0001, "R7 write without read ignored");
        bwr(C0 + 5, 0, 16'h0001);
        brd(C0 + 5, 0, 16'h0001, "R7 write of 1 ignored");
        bwr(C0 + 5, 0, 16'h00FE);
        brd(C0 + 5, 0, 16'h0000, "R7 read then write 0 clears");
        check("R7 irq low after ack", {15'd0, irq[0]}, 16'h0000);

        // R8 compare event coincides with clearing write
        bwr(C0 + 8, 1, 16'd3);
        bwr(C0 + 6, 1, 16'h0000);
        bwr(A_GO, 0, 16'h0001);
        idle(4);
        brd(C0 + 5, 0, 16'h0001, "R8 first event seen");
        idle(2);
        bwr(C0 + 5, 0, 16'h00FE);
        check("R8 event wins over clear", {15'd0, irq[0]}, 16'h0001);
        bwr(A_GO, 0, 16'h0000);
        bwr(C0 + 5, 0, 16'h00FE);
        brd(C0 + 5, 0, 16'h0001, "R8 needs fresh read");
        bwr(C0 + 5, 0, 16'h00FE);
        brd(C0 + 5, 0, 16'h0000, "R8 cleared after fresh read");

        // R5 free running through compare and wrap
        bwr(C0 + 0, 0, 16'h0000);
        bwr(C0 + 8, 1, 16'hFFFE);
        bwr(C0 + 6, 1, 16'hFFFC);
        bwr(A_GO, 0, 16'h0001);
        idle(4);
        bwr(A_GO, 0, 16'h0000);
        brd(C0 + 6, 1, 16'h0001, "R5 counter wrapped past compare");
        brd(C0 + 5, 0, 16'h0001, "R5 flag set without clear");

        idle(2);
        summary();
        $finish;
    end
endmodule